// File: doc/BRIEF.md
# Exception Source Classifier and Prioritizer

This block runs beside the instruction decoder of a small pipelined RISC core that has delayed branches. Each cycle it looks at the decoder's flags for the instruction in the decode slot, at the address-error and interrupt requests, at the floating-point status flags, and at the reset sources. It keeps track of whether the decode slot is the delay slot of a delayed branch. Undefined code and PC-changing instructions that land in that slot are classified apart from ordinary undefined code.

All candidate sources compete in one fixed priority chain. The winner is reported as a one-cycle start pulse with a 4-bit code on the clock edge that follows. Address errors and interrupts are remembered when they are raised. They compete only in a cycle where the executing instruction reports completion. A trap decoded outside a delay slot waits for its execute stage in the same way.

The core uses the pulse and the code to redirect fetch. Vector fetch and state saving happen outside this block.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_pin` is low, `exc_start` and `exc_code` are 0 and all remembered state (delay-slot flag, pending trap, pending address error, pending interrupt) is cleared asynchronously.
- R2: On the first clock edge with `rst_pin` high after it was low, and on any edge where `wdt_ovf` is 1 with `wdt_mode` 0, a power-on start is issued with code 1.
- R3: On an edge where `wdt_ovf` is 1 with `wdt_mode` 1, a manual-reset start is issued with code 2.
- R4: A valid decode with `dec_undef` while the delay-slot flag is clear issues a general-illegal start with code 6 on that edge.
- R5: A valid decode with `dec_dbranch` sets the delay-slot flag, which stays set through cycles without a valid decode and is consumed by the next valid decode. Undefined code decoded while the flag is set gives code 7, not code 6.
- R6: While the delay-slot flag is set, a valid decode of a PC-rewriting instruction (`dec_pcwrite`), a trap (`dec_trap`) or a delayed branch (`dec_dbranch`) gives code 7. A trap decoded there is not recorded as a pending trap.
- R7: A trap decoded outside a delay slot is remembered. It starts with code 5 on the first later edge where `exe_done` is 1.
- R8: `addr_err` and `irq_req` are remembered. Each starts on a later edge where `exe_done` is 1, with code 3 for an address error and code 4 for an interrupt.
- R9: `fp_inv` or `fp_dz` issues a floating-point start with code 8 on that edge.
- R10: When several sources qualify on one edge, the lowest code wins: power-on 1, manual 2, address error 3, interrupt 4, trap 5, general illegal 6, slot illegal 7, floating point 8.
- R11: Any start, and a `flush`, clear the delay-slot flag and the pending trap. The winning pending address error or interrupt is cleared and the losing one is kept. A reset start (code 1 or 2) clears both.
- R12: `exc_start` is high for exactly the edges where a start is issued, and `exc_code` is 0 whenever `exc_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin | input | 1 | External reset pin, low clears all state, rising releases power-on |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_mode | input | 1 | Watchdog reset kind: 0 power-on, 1 manual |
| dec_valid | input | 1 | Decode slot holds an instruction this cycle |
| dec_undef | input | 1 | Decoded code is undefined |
| dec_trap | input | 1 | Decoded instruction is a trap |
| dec_dbranch | input | 1 | Decoded instruction is a delayed branch |
| dec_pcwrite | input | 1 | Decoded instruction rewrites the PC |
| flush | input | 1 | Pipeline flush |
| addr_err | input | 1 | Address error detected |
| irq_req | input | 1 | Interrupt request accepted at decode |
| exe_done | input | 1 | Executing instruction completes this cycle |
| fp_inv | input | 1 | Floating-point invalid operation |
| fp_dz | input | 1 | Floating-point divide by zero |
| exc_start | output | 1 | One-cycle exception start pulse |
| exc_code | output | 4 | Code of the winning source, 0 when idle |

## Verification
The hardest case to reach is a delay-slot flag that survives decode bubbles and then meets an offending instruction. In the same area, a trap in the slot must be turned into a slot-illegal start and not into a pending trap that fires later on `exe_done`. Directed sequences build these cases: a delayed branch, an idle decode cycle, then an undefined, PC-rewriting or trap instruction, followed by an `exe_done` that must stay quiet. A flush placed between branch and undefined code shows the fall back to code 6. Seeded random traffic with a high delayed-branch rate and sparse side requests then mixes pending address errors, interrupts and traps, so that many priority collisions occur.

// File: rtl/exc_arbiter.sv
module exc_arbiter (
  input  logic       clk,
  input  logic       rst_pin,
  input  logic       wdt_ovf,
  input  logic       wdt_mode,
  input  logic       dec_valid,
  input  logic       dec_undef,
  input  logic       dec_trap,
  input  logic       dec_dbranch,
  input  logic       dec_pcwrite,
  input  logic       flush,
  input  logic       addr_err,
  input  logic       irq_req,
  input  logic       exe_done,
  input  logic       fp_inv,
  input  logic       fp_dz,
  output logic       exc_start,
  output logic [3:0] exc_code
);
  localparam int NSRC = 8;

  logic pin_q, slot_q, ae_q, irq_q, trap_q;
  logic [NSRC-1:0] req;
  logic [3:0] win;
  logic go, hard;

  assign req[0] = ~pin_q | (wdt_ovf & ~wdt_mode);
  assign req[1] = wdt_ovf & wdt_mode;
  assign req[2] = ae_q & exe_done;
  assign req[3] = irq_q & exe_done;
  assign req[4] = trap_q & exe_done;
  assign req[5] = dec_valid & dec_undef & ~slot_q;
  assign req[6] = dec_valid & slot_q & (dec_undef | dec_pcwrite | dec_dbranch | dec_trap);
  assign req[7] = fp_inv | fp_dz;

  always_comb begin
    win = 4'd0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) win = 4'(i + 1);
  end

  assign go   = |req;
  assign hard = req[0] | req[1];

  always_ff @(posedge clk or negedge rst_pin) begin
    if (!rst_pin) begin
      pin_q     <= 1'b0;
      slot_q    <= 1'b0;
      ae_q      <= 1'b0;
      irq_q     <= 1'b0;
      trap_q    <= 1'b0;
      exc_start <= 1'b0;
      exc_code  <= 4'd0;
    end else begin
      pin_q     <= 1'b1;
      exc_start <= go;
      exc_code  <= win;
      ae_q      <= hard ? 1'b0 : ((ae_q & (win != 4'd3)) | addr_err);
      irq_q     <= hard ? 1'b0 : ((irq_q & (win != 4'd4)) | irq_req);
      if (go || flush) begin
        slot_q <= 1'b0;
        trap_q <= 1'b0;
      end else begin
        if (dec_valid) slot_q <= dec_dbranch;
        trap_q <= trap_q | (dec_valid & dec_trap & ~slot_q);
      end
    end
  end
endmodule

module exc_arbiter_chk (
  input logic       clk,
  input logic       rst_pin,
  input logic       wdt_ovf,
  input logic       wdt_mode,
  input logic       dec_valid,
  input logic       dec_undef,
  input logic       exe_done,
  input logic       fp_inv,
  input logic       fp_dz,
  input logic       pin_q,
  input logic       slot_q,
  input logic       exc_start,
  input logic [3:0] exc_code
);
  // R12
  start_code_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    exc_start == (exc_code != 4'd0));
  // R2
  po_wdt_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    wdt_ovf && !wdt_mode |=> exc_start && exc_code == 4'd1);
  // R3
  man_wdt_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    wdt_ovf && wdt_mode && pin_q |=> exc_code == 4'd2);
  // R4
  gen_ill_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    exc_code == 4'd6 |-> $past(dec_valid && dec_undef && !slot_q));
  // R5
  slot_ill_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    exc_code == 4'd7 |-> $past(slot_q && dec_valid));
  // R7
  trap_exec_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    exc_code == 4'd5 |-> $past(exe_done));
  // R8
  defer_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    (exc_code == 4'd3 || exc_code == 4'd4) |-> $past(exe_done));
  // R9
  fpu_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    exc_code == 4'd8 |-> $past(fp_inv || fp_dz));
endmodule

bind exc_arbiter exc_arbiter_chk chk (
  .clk(clk), .rst_pin(rst_pin), .wdt_ovf(wdt_ovf), .wdt_mode(wdt_mode),
  .dec_valid(dec_valid), .dec_undef(dec_undef), .exe_done(exe_done),
  .fp_inv(fp_inv), .fp_dz(fp_dz), .pin_q(pin_q), .slot_q(slot_q),
  .exc_start(exc_start), .exc_code(exc_code)
);

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;
  logic clk = 1'b0;
  logic rst_pin = 1'b0, wdt_ovf = 0, wdt_mode = 0, dec_valid = 0, dec_undef = 0;
  logic dec_trap = 0, dec_dbranch = 0, dec_pcwrite = 0, flush = 0, addr_err = 0;
  logic irq_req = 0, exe_done = 0, fp_inv = 0, fp_dz = 0;
  logic exc_start;
  logic [3:0] exc_code;
  int checks = 0, errors = 0;

  logic m_pin, m_slot, m_ae, m_irq, m_trap;

  exc_arbiter uut (.*);

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd1: return "R2";  4'd2: return "R3";  4'd3, 4'd4: return "R8";
      4'd5: return "R7";  4'd6: return "R4";  4'd7: return "R5";
      4'd8: return "R9";  default: return "R12";
    endcase
  endfunction

  function automatic logic [3:0] expect_code();
    if (!m_pin || (wdt_ovf && !wdt_mode)) return 4'd1;
    if (wdt_ovf && wdt_mode) return 4'd2;
    if (m_ae && exe_done) return 4'd3;
    if (m_irq && exe_done) return 4'd4;
    if (m_trap && exe_done) return 4'd5;
    if (dec_valid && dec_undef && !m_slot) return 4'd6;
    if (dec_valid && m_slot && (dec_undef || dec_pcwrite || dec_dbranch || dec_trap)) return 4'd7;
    if (fp_inv || fp_dz) return 4'd8;
    return 4'd0;
  endfunction

  task automatic compare(input logic [3:0] exp, input string t);
    checks++;
    if (exc_code !== exp || exc_start !== (exp != 4'd0)) begin
      errors++;
      $display("FAIL %s code=%0d start=%0b expected code=%0d start=%0b",
               t, exc_code, exc_start, exp, exp != 4'd0);
    end
  endtask

  task automatic model_reset();
    m_pin = 0; m_slot = 0; m_ae = 0; m_irq = 0; m_trap = 0;
  endtask

  // inputs already set (after negedge); advance one edge and check
  task automatic step(input string t);
    logic [3:0] e;
    string tt;
    if (!rst_pin) begin
      model_reset();
      #1 compare(4'd0, "R1");
      @(posedge clk); #1 compare(4'd0, "R1");
    end else begin
      e = expect_code();
      tt = (t == "") ? tag_of(e) : t;
      if (e == 4'd1 || e == 4'd2) begin
        m_ae = 0; m_irq = 0;
      end else begin
        m_ae = (m_ae && e != 4'd3) || addr_err;
        m_irq = (m_irq && e != 4'd4) || irq_req;
      end
      if (e != 0 || flush) begin
        m_slot = 0; m_trap = 0;
      end else begin
        m_trap = m_trap || (dec_valid && dec_trap && !m_slot);
        if (dec_valid) m_slot = dec_dbranch;
      end
      m_pin = 1;
      @(posedge clk); #1 compare(e, tt);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wdt_ovf = 0; dec_valid = 0; dec_undef = 0; dec_trap = 0; dec_dbranch = 0;
    dec_pcwrite = 0; flush = 0; addr_err = 0; irq_req = 0; exe_done = 0;
    fp_inv = 0; fp_dz = 0;
  endtask

  task automatic dec(input logic u, tr, db, pc);
    idle(); dec_valid = 1; dec_undef = u; dec_trap = tr; dec_dbranch = db; dec_pcwrite = pc;
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk);
    step("R1");
    rst_pin = 1; step("R2");
    idle(); step("R12");
    wdt_ovf = 1; wdt_mode = 0; step("R2");
    idle(); wdt_ovf = 1; wdt_mode = 1; step("R3");
    // R10: manual reset beats a pending address error, and clears it
    idle(); addr_err = 1; step("R8");
    idle(); wdt_ovf = 1; wdt_mode = 1; exe_done = 1; step("R10");
    idle(); exe_done = 1; step("R11");
    // R4 plain undefined
    dec(1, 0, 0, 0); step("R4");
    // R5 slot undefined, across a bubble
    dec(0, 0, 1, 0); step("R5");
    idle(); step("R5");
    dec(1, 0, 0, 0); step("R5");
    // R6 PC-rewrite and trap in slot; trap not kept pending
    dec(0, 0, 1, 0); step("R6");
    dec(0, 0, 0, 1); step("R6");
    dec(0, 0, 1, 0); step("R6");
    dec(0, 1, 0, 1); step("R6");
    idle(); exe_done = 1; step("R6");
    dec(0, 0, 1, 0); step("R6");
    dec(0, 0, 1, 0); step("R6");
    // R11 flush clears the slot flag
    dec(0, 0, 1, 0); step("R11");
    idle(); flush = 1; step("R11");
    dec(1, 0, 0, 0); step("R11");
    // R7 trap waits for execute
    dec(0, 1, 0, 1); step("R7");
    idle(); step("R7");
    idle(); exe_done = 1; step("R7");
    // R8 / R10 / R11: both pending, address error first, interrupt kept
    idle(); addr_err = 1; irq_req = 1; step("R8");
    idle(); exe_done = 1; step("R10");
    idle(); exe_done = 1; step("R11");
    // R9 and R10 against undefined code
    idle(); fp_dz = 1; step("R9");
    dec(1, 0, 0, 0); fp_inv = 1; step("R10");
    // R1 asynchronous clear of pending state
    idle(); irq_req = 1; step("R8");
    rst_pin = 0; step("R1");
    rst_pin = 1; step("R2");
    idle(); exe_done = 1; step("R1");

    for (int n = 0; n < 4000; n++) begin
      idle();
      dec_valid   = ($urandom % 10) < 7;
      dec_undef   = ($urandom % 10) == 0;
      dec_trap    = ($urandom % 12) == 0;
      dec_dbranch = ($urandom % 5) == 0;
      dec_pcwrite = dec_trap || dec_dbranch || (($urandom % 10) == 0);
      flush       = ($urandom % 20) == 0;
      addr_err    = ($urandom % 30) == 0;
      irq_req     = ($urandom % 25) == 0;
      exe_done    = ($urandom % 2) == 0;
      fp_inv      = ($urandom % 40) == 0;
      fp_dz       = ($urandom % 40) == 0;
      wdt_ovf     = ($urandom % 150) == 0;
      wdt_mode    = 1'($urandom % 2);
      rst_pin     = ($urandom % 300) != 0;
      step("");
      rst_pin = 1;
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule